// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block drives the repetition of a byte or word string primitive (store, move, compare, scan) under a repeat prefix. It holds a repetition count, a source index, a destination index and a direction flag. For each element it raises a memory request carrying the current indices, waits for the completion handshake, and then steps the indices and decrements the count. The zero-result flag that comes back with compare and scan completions can end the repetition early.

The same count register also serves a standalone decrement-and-branch command. This command reduces the count by one and reports whether the branch is taken. Memory access, the ALU and instruction decode lie outside the block. They are represented by a request/done handshake, a zero-result input and single-cycle command strobes.

Top module: `rep_string_seq`

## Requirements
- R1: After a synchronous reset, the count, both indices and the direction flag are zero, `mem_req` is low, and `done` and `loop_taken` are low.
- R2: A string command taken while idle with a nonzero count raises `mem_req` on the next cycle. Each cycle in which `mem_req` and `mem_done` are both high completes one iteration and decrements the count by one. With the plain repeat (`str_rep` 0 or 3), iterations continue until the count reaches zero. `done` pulses for one cycle in the cycle after the last completion, and `mem_req` is then low.
- R3: A string command taken while the count is zero performs no iteration. `mem_req` stays low, and `done` is high on the next cycle.
- R4: With while-equal (`str_rep` 1) and a compare (`str_op` 2) or scan (`str_op` 3), repetition ends after the first completion whose `mem_zero` is 0. The count has already been decremented for that iteration.
- R5: With while-not-equal (`str_rep` 2) and a compare or scan, repetition ends after the first completion whose `mem_zero` is 1. The count has already been decremented for that iteration.
- R6: For store (`str_op` 0) and move (`str_op` 1), `mem_zero` is ignored. The while-equal and while-not-equal variants run the full count, like the plain repeat.
- R7: After each iteration, an index that steps changes by 1 for bytes (`str_word` 0) or 2 for words (`str_word` 1). It moves upward when the direction flag is 0 and downward when it is 1, modulo 2^ADDR_W. The destination index steps on every operation. The source index steps only for move and compare.
- R8: While `mem_req` is high and `mem_done` is low, the request, the addresses, the count, `mem_op` and `mem_word` hold their values. The addresses equal the current indices.
- R9: A loop command (`loop_start`) taken while idle decrements the count by one, wrapping from 0 to all ones. On the next cycle `done` pulses, and `loop_taken` is high exactly when the new count is nonzero.
- R10: While a repetition is running, `ld_en`, `str_start` and `loop_start` have no effect. When idle, `ld_en` loads the count, both indices and the direction flag. A string or loop command in the same cycle as `ld_en` is dropped. A string command takes precedence over a loop command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load count, indices and direction (idle only) |
| ld_count | input | CNT_W (16) | Count value to load |
| ld_src | input | ADDR_W (16) | Source index to load |
| ld_dst | input | ADDR_W (16) | Destination index to load |
| ld_dir | input | 1 | Direction flag to load (0 up, 1 down) |
| str_start | input | 1 | Start a repeated string operation |
| str_op | input | 2 | 0 store, 1 move, 2 compare, 3 scan |
| str_rep | input | 2 | 0 plain, 1 while-equal, 2 while-not-equal, 3 plain |
| str_word | input | 1 | Element size: 0 byte, 1 word |
| loop_start | input | 1 | Decrement-and-branch command |
| mem_req | output | 1 | Memory operation request |
| mem_op | output | 2 | Primitive of the current request |
| mem_word | output | 1 | Element size of the current request |
| mem_src_addr | output | ADDR_W (16) | Source index for the request |
| mem_dst_addr | output | ADDR_W (16) | Destination index for the request |
| mem_done | input | 1 | Completion of the current request |
| mem_zero | input | 1 | Zero result accompanying `mem_done` |
| done | output | 1 | One-cycle end-of-command pulse |
| loop_taken | output | 1 | Branch taken, valid with `done` after a loop command |
| count_out | output | CNT_W (16) | Current count |

## Verification
The bench builds the block with CNT_W = 4 and ADDR_W = 8. With these widths, the loop command wrapping from 0 to 15 and index wrap-around in both directions are reached in a few cycles. Runs with early termination on compare and scan fit in short scenarios, and so do runs that ignore the zero flag for store and move. The memory responder varies its latency from zero to two cycles, which exercises back-to-back iterations as well as held requests.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam logic [1:0] OP_STORE = 2'd0;
  localparam logic [1:0] OP_MOVE  = 2'd1;
  localparam logic [1:0] OP_CMP   = 2'd2;
  localparam logic [1:0] OP_SCAN  = 2'd3;

  localparam logic [1:0] REP_ALL  = 2'd0;
  localparam logic [1:0] REP_EQ   = 2'd1;
  localparam logic [1:0] REP_NE   = 2'd2;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/rss_count_reg.sv
module rss_count_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             dec,
  output logic [CNT_W-1:0] q,
  output logic [CNT_W-1:0] q_minus
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb q_minus = q - ONE;

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (dec) q <= q_minus;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld && !dec) |=> $stable(q)); // R10
endmodule

// File: rtl/rss_index_step.sv
module rss_index_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              dir,
  input  logic              word,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] stride;

  always_comb begin
    stride = word ? ADDR_W'(2) : ADDR_W'(1);
    nxt    = dir ? (cur - stride) : (cur + stride);
  end
endmodule

// File: rtl/rss_term_eval.sv
module rss_term_eval
  import rss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_after,
  input  logic [1:0]       op,
  input  logic [1:0]       rep,
  input  logic             zero,
  output logic             stop
);
  logic flag_op;

  always_comb begin
    flag_op = (op == OP_CMP) || (op == OP_SCAN);
    stop = (cnt_after == '0)
        || (flag_op && (rep == REP_EQ) && !zero)
        || (flag_op && (rep == REP_NE) && zero);
  end
endmodule

// File: rtl/rep_string_seq.sv
module rep_string_seq
  import rss_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic              ld_dir,
  input  logic              str_start,
  input  logic [1:0]        str_op,
  input  logic [1:0]        str_rep,
  input  logic              str_word,
  input  logic              loop_start,
  output logic              mem_req,
  output logic [1:0]        mem_op,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_src_addr,
  output logic [ADDR_W-1:0] mem_dst_addr,
  input  logic              mem_done,
  input  logic              mem_zero,
  output logic              done,
  output logic              loop_taken,
  output logic [CNT_W-1:0]  count_out
);
  localparam int NIDX = 2;
  localparam int SRC  = 0;
  localparam int DST  = 1;
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  seq_state_e        state;
  logic [1:0]        op_q, rep_q;
  logic              word_q, dir_q;
  logic [ADDR_W-1:0] idx_q   [NIDX];
  logic [ADDR_W-1:0] idx_nxt [NIDX];
  logic [ADDR_W-1:0] idx_ld  [NIDX];
  logic              idx_en  [NIDX];
  logic [CNT_W-1:0]  cnt_q, cnt_dec_val;
  logic              idle, acc_ld, acc_str, acc_loop, iter_end, stop, src_moves;

  always_comb begin
    idle      = (state == ST_IDLE);
    acc_ld    = idle && ld_en;
    acc_str   = idle && !ld_en && str_start;
    acc_loop  = idle && !ld_en && !str_start && loop_start;
    iter_end  = (state == ST_RUN) && mem_done;
    src_moves = (op_q == OP_MOVE) || (op_q == OP_CMP);
  end

  assign idx_ld[SRC] = ld_src;
  assign idx_ld[DST] = ld_dst;
  assign idx_en[SRC] = src_moves;
  assign idx_en[DST] = 1'b1;

  rss_count_reg #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .ld      (acc_ld),
    .ld_val  (ld_count),
    .dec     (iter_end || acc_loop),
    .q       (cnt_q),
    .q_minus (cnt_dec_val)
  );

  rss_term_eval #(.CNT_W(CNT_W)) u_term (
    .cnt_after (cnt_dec_val),
    .op        (op_q),
    .rep       (rep_q),
    .zero      (mem_zero),
    .stop      (stop)
  );

  for (genvar g = 0; g < NIDX; g++) begin : g_idx
    rss_index_step #(.ADDR_W(ADDR_W)) u_step (
      .cur  (idx_q[g]),
      .dir  (dir_q),
      .word (word_q),
      .nxt  (idx_nxt[g])
    );

    always_ff @(posedge clk) begin
      if (rst)                        idx_q[g] <= '0;
      else if (acc_ld)                idx_q[g] <= idx_ld[g];
      else if (iter_end && idx_en[g]) idx_q[g] <= idx_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_STORE;
      rep_q      <= REP_ALL;
      word_q     <= 1'b0;
      dir_q      <= 1'b0;
      done       <= 1'b0;
      loop_taken <= 1'b0;
    end else begin
      done       <= 1'b0;
      loop_taken <= 1'b0;
      if (acc_ld) dir_q <= ld_dir;
      if (acc_str) begin
        op_q   <= str_op;
        rep_q  <= str_rep;
        word_q <= str_word;
        if (cnt_q == '0) done  <= 1'b1;
        else             state <= ST_RUN;
      end
      if (acc_loop) begin
        done       <= 1'b1;
        loop_taken <= (cnt_dec_val != '0);
      end
      if (iter_end && stop) begin
        state <= ST_IDLE;
        done  <= 1'b1;
      end
    end
  end

  assign mem_req      = (state == ST_RUN);
  assign mem_op       = op_q;
  assign mem_word     = word_q;
  assign mem_src_addr = idx_q[SRC];
  assign mem_dst_addr = idx_q[DST];
  assign count_out    = cnt_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_src_addr) && $stable(mem_dst_addr)
                                && $stable(count_out) && $stable(mem_op))); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done) |=> (count_out == $past(count_out) - ONE_C)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req); // R2
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && !ld_en && str_start && count_out == '0) |=> (!mem_req && done)); // R3
  AST_EQ_STOP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done && rep_q == REP_EQ && mem_op[1] && !mem_zero) |=> (!mem_req && done)); // R4
  AST_NE_STOP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done && rep_q == REP_NE && mem_op[1] && mem_zero) |=> (!mem_req && done)); // R5
  AST_TAKEN_NZ: assert property (@(posedge clk) disable iff (rst)
    loop_taken |-> (done && count_out != '0)); // R9
endmodule

// File: tb/tb_rep_string_seq.sv
`timescale 1ns/1ps
module tb_rep_string_seq;
  localparam int CW = 4;
  localparam int AW = 8;
  localparam int CM = (1 << CW) - 1;
  localparam int AM = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 0, ld_dir = 0, str_start = 0, str_word = 0, loop_start = 0;
  logic [CW-1:0] ld_count = '0;
  logic [AW-1:0] ld_src = '0, ld_dst = '0;
  logic [1:0] str_op = '0, str_rep = '0;
  logic mem_req, mem_word, mem_done = 0, mem_zero = 0, done, loop_taken;
  logic [1:0] mem_op;
  logic [AW-1:0] mem_src_addr, mem_dst_addr;
  logic [CW-1:0] count_out;

  always #4 clk = ~clk;

  rep_string_seq #(.CNT_W(CW), .ADDR_W(AW)) dut (.*);

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0, hs = 0;
  int zq[$];
  bit cmp_on = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_run, m_cnt, m_src, m_dst, m_dir, m_op, m_rep, m_word, m_done, m_tk;
  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_cnt = 0; m_src = 0; m_dst = 0; m_dir = 0;
      m_op = 0; m_rep = 0; m_word = 0; m_done = 0; m_tk = 0;
    end else begin
      m_done = 0; m_tk = 0;
      if (m_run == 0) begin
        if (ld_en) begin
          m_cnt = ld_count; m_src = ld_src; m_dst = ld_dst; m_dir = ld_dir;
        end else if (str_start) begin
          m_op = str_op; m_rep = str_rep; m_word = str_word;
          if (m_cnt == 0) m_done = 1; else m_run = 1;
        end else if (loop_start) begin
          m_cnt = (m_cnt - 1) & CM;
          m_done = 1;
          m_tk = (m_cnt != 0);
        end
      end else if (mem_done) begin
        int step;
        bit stop;
        step = m_word ? 2 : 1;
        if (m_dir) step = -step;
        m_dst = (m_dst + step) & AM;
        if (m_op == 1 || m_op == 2) m_src = (m_src + step) & AM;
        m_cnt = (m_cnt - 1) & CM;
        stop = (m_cnt == 0);
        if (m_op >= 2 && m_rep == 1 && !mem_zero) stop = 1;
        if (m_op >= 2 && m_rep == 2 && mem_zero) stop = 1;
        if (stop) begin m_run = 0; m_done = 1; end
      end
    end
  end

  // Per-clock comparison and memory responder
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 mem_req", mem_req, m_run);
      chk("R7 mem_src_addr", mem_src_addr, m_src);
      chk("R7 mem_dst_addr", mem_dst_addr, m_dst);
      chk("R2 count_out", count_out, m_cnt);
      chk("R2 done", done, m_done);
      chk("R9 loop_taken", loop_taken, m_tk);
      if (mem_req) begin
        chk("R8 mem_op", mem_op, m_op);
        chk("R8 mem_word", mem_word, m_word);
      end
    end
    if (!mem_req) begin
      mem_done <= 0; wcnt = 0;
    end else if (wcnt >= lat) begin
      mem_done <= 1;
      mem_zero <= (zq.size() > 0) ? zq.pop_front()[0] : 1'b0;
      hs++; wcnt = 0;
    end else begin
      mem_done <= 0; wcnt++;
    end
  end

  task automatic load(int c, int s, int d, int dir);
    @(negedge clk);
    ld_en = 1; ld_count = c[CW-1:0]; ld_src = s[AW-1:0]; ld_dst = d[AW-1:0]; ld_dir = dir[0];
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic run_str(string tag, int op, int rep, int word,
                         int e_it, int e_cnt, int e_src, int e_dst);
    int guard = 0;
    @(negedge clk);
    hs = 0;
    str_start = 1; str_op = op[1:0]; str_rep = rep[1:0]; str_word = word[0];
    @(negedge clk);
    str_start = 0;
    while (!done && guard < 300) begin @(negedge clk); guard++; end
    chk({tag, " done seen"}, done, 1);
    chk({tag, " iterations"}, hs, e_it);
    chk({tag, " count"}, count_out, e_cnt);
    chk({tag, " src"}, mem_src_addr, e_src);
    chk({tag, " dst"}, mem_dst_addr, e_dst);
    chk({tag, " req low at done"}, mem_req, 0);
  endtask

  task automatic run_loop(string tag, int e_cnt, int e_tk);
    @(negedge clk);
    loop_start = 1;
    @(negedge clk);
    loop_start = 0;
    chk({tag, " done"}, done, 1);
    chk({tag, " taken"}, loop_taken, e_tk);
    chk({tag, " count"}, count_out, e_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset mem_req", mem_req, 0);
    chk("R1 reset count", count_out, 0);
    chk("R1 reset src", mem_src_addr, 0);
    chk("R1 reset dst", mem_dst_addr, 0);
    chk("R1 reset done", done, 0);
    cmp_on = 1;

    // R2 plain store, bytes, upward
    lat = 0; load(3, 'h10, 'h20, 0);
    run_str("R2 store plain", 0, 0, 0, 3, 0, 'h10, 'h23);
    // R7 move words downward with wrap
    lat = 1; load(2, 'h01, 'h80, 1);
    run_str("R7 move word down", 1, 3, 1, 2, 0, 'hFD, 'h7C);
    // R4 compare while-equal
    lat = 2; zq = '{1, 1, 0}; load(5, 'h40, 'h50, 0);
    run_str("R4 compare eq", 2, 1, 0, 3, 2, 'h43, 'h53);
    // R5 scan while-not-equal, src fixed, dst wraps
    lat = 0; zq = '{0, 1}; load(4, 'h00, 'hFE, 0);
    run_str("R5 scan ne", 3, 2, 1, 2, 2, 'h00, 'h02);
    // R6 zero flag ignored for store and move
    zq.delete(); load(2, 5, 9, 0);
    run_str("R6 store eq", 0, 1, 0, 2, 0, 5, 'h0B);
    zq = '{1, 1}; load(2, 5, 9, 1);
    run_str("R6 move ne", 1, 2, 0, 2, 0, 3, 7);
    zq.delete();
    // R3 zero count
    load(0, 'h33, 'h44, 0);
    run_str("R3 zero count", 2, 0, 0, 0, 0, 'h33, 'h44);
    // R9 loop command
    load(3, 0, 0, 0);
    run_loop("R9 loop 3", 2, 1);
    load(1, 0, 0, 0);
    run_loop("R9 loop 1", 0, 0);
    run_loop("R9 loop wrap", 15, 1);
    // R10 commands ignored while busy
    lat = 2; load(3, 0, 0, 0);
    @(negedge clk);
    hs = 0; str_start = 1; str_op = 0; str_rep = 0; str_word = 0;
    @(negedge clk);
    str_start = 0;
    ld_en = 1; ld_count = 9; ld_dst = 'h77; ld_src = 'h66; loop_start = 1;
    @(negedge clk);
    ld_en = 0; loop_start = 0; str_start = 1; str_op = 3;
    @(negedge clk);
    str_start = 0;
    begin
      int guard = 0;
      while (!done && guard < 300) begin @(negedge clk); guard++; end
    end
    chk("R10 busy iterations", hs, 3);
    chk("R10 busy count", count_out, 0);
    chk("R10 busy dst", mem_dst_addr, 3);
    chk("R10 busy src", mem_src_addr, 0);
    // R10 load wins over same-cycle start
    @(negedge clk);
    ld_en = 1; ld_count = 2; ld_src = 1; ld_dst = 2; str_start = 1; str_op = 0;
    @(negedge clk);
    ld_en = 0; str_start = 0;
    chk("R10 load precedence req", mem_req, 0);
    chk("R10 load precedence count", count_out, 2);
    @(negedge clk);
    chk("R10 load precedence no done", done, 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule